// File: doc/BRIEF.md
# Multi-Function Bus Address Decoder

This block sits behind the address phase of a backplane slave and decides which of its eight programmable functions, if any, owns an access. Every function holds three settings: a compare word (upper address bits plus an expected address-modifier field), an address mask, and a 64-bit capability mask indexed by the 6-bit address-modifier code. The modifier code fixes the width of the address in play (16, 24 or 32 bits). Each function compares the truncated address against its compare bits under its own mask. It also checks that the modifier code is allowed by its capability mask and, when the build enables it, equal to the modifier field of its compare word.

When an access is presented with `req_i` high, the result appears one clock later: a hit flag, the number of the winning function, and the local offset. The offset is the truncated address with the masked (decoded) bits cleared. When several functions match, the lowest-numbered one wins. Each function serves one address space and one transfer kind, so a master that uses several spaces or transfer kinds programs several functions.

Top module: `multi_fn_decoder`

## Requirements
- R1: While `rst_ni` is low, `hit_o` is 0, `fn_o` is 0 and `addr_o` is 0.
- R2: Modifier codes 0x29 and 0x2D select a 16-bit address. Codes 0x2F and 0x38 to 0x3F select 24 bits. Codes 0x08 to 0x0F select 32 bits. Address bits above the selected width are ignored. Any other code matches no function.
- R3: Let M be `adem[31:8]` (bits 7:0 taken as zero), limited to the active width. A function's address test passes when (truncated address AND M) equals (compare word AND M).
- R4: A function matches only if bit `am_i` of its capability mask is 1.
- R5: With `DECODE_AM`=1, a function also needs bits 7:2 of its compare word to equal `am_i`. With `DECODE_AM`=0, those bits are ignored.
- R6: When several functions match, `fn_o` gives the lowest index.
- R7: A function whose mask is zero within the active width never matches. A function whose capability mask is all zero never matches.
- R8: On a hit, `addr_o` is the truncated address with the bits of M cleared, so bits 7:0 always pass through.
- R9: Outputs change one clock after the access is sampled. `hit_o` is 1 only if `req_i` was high and some function matched. If `req_i` was low or nothing matched, `hit_o` is 0 and `fn_o`/`addr_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access present this cycle |
| addr_i | input | 32 | Access address |
| am_i | input | 6 | Address-modifier code |
| ader_i | input | 8x32 | Per-function compare word; bits 7:2 hold the expected modifier |
| adem_i | input | 8x32 | Per-function address mask; bits 31:8 used |
| amcap_i | input | 8x64 | Per-function capability mask, one bit per modifier code |
| hit_o | output | 1 | Some function claimed the last sampled access |
| fn_o | output | 3 | Index of the winning function |
| addr_o | output | 32 | Local offset of the winning function |

## Verification
The bench builds two copies side by side from the same stimulus: one with `DECODE_AM`=1 and one with `DECODE_AM`=0, both with eight functions and 32-bit addresses. The pair makes the modifier-field test visible as a difference between the two outputs. The same access can miss on one copy and hit on the other, while the capability mask gates both alike. The programmed set includes overlapping functions, a zero mask, an empty capability mask and a mask that lies only above the 24-bit width. These reach the priority, truncation and never-match cases.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int unsigned AM_W    = 6;
  localparam int unsigned AMF_LSB = 2;

  typedef enum logic [1:0] {
    SPACE_NONE,
    SPACE_A16,
    SPACE_A24,
    SPACE_A32
  } space_e;

  localparam logic [AM_W-1:0] AM_A16_USR = 6'h29;
  localparam logic [AM_W-1:0] AM_A16_SUP = 6'h2D;
  localparam logic [AM_W-1:0] AM_CFG     = 6'h2F;
endpackage

// File: rtl/mfd_space_class.sv
module mfd_space_class
  import mfd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [AM_W-1:0]   am_i,
  output space_e            space_o,
  output logic [ADDR_W-1:0] width_mask_o
);
  localparam logic [ADDR_W-1:0] M16 = {{(ADDR_W-16){1'b0}}, {16{1'b1}}};
  localparam logic [ADDR_W-1:0] M24 = {{(ADDR_W-24){1'b0}}, {24{1'b1}}};
  localparam logic [ADDR_W-1:0] M32 = {{(ADDR_W-32){1'b0}}, {32{1'b1}}};

  always_comb begin
    if (am_i == AM_A16_USR || am_i == AM_A16_SUP)
      space_o = SPACE_A16;
    else if (am_i[5:3] == 3'b111 || am_i == AM_CFG)
      space_o = SPACE_A24;
    else if (am_i[5:3] == 3'b001)
      space_o = SPACE_A32;
    else
      space_o = SPACE_NONE;
  end

  always_comb begin
    unique case (space_o)
      SPACE_A16: width_mask_o = M16;
      SPACE_A24: width_mask_o = M24;
      SPACE_A32: width_mask_o = M32;
      default:   width_mask_o = '0;
    endcase
  end
endmodule

// File: rtl/mfd_func.sv
module mfd_func
  import mfd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MASK_LSB  = 8,
  parameter bit          DECODE_AM = 1'b1,
  localparam int unsigned CAP_W    = 1 << AM_W
) (
  input  logic [ADDR_W-1:0] addr_t_i,
  input  logic [ADDR_W-1:0] width_mask_i,
  input  logic              space_ok_i,
  input  logic [AM_W-1:0]   am_i,
  input  logic [ADDR_W-1:0] ader_i,
  input  logic [ADDR_W-1:0] adem_i,
  input  logic [CAP_W-1:0]  amcap_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] offset_o
);
  localparam logic [ADDR_W-1:0] HI_MASK = {{(ADDR_W-MASK_LSB){1'b1}}, {MASK_LSB{1'b0}}};

  logic [ADDR_W-1:0] eff_mask;
  logic              cmp_ok, cap_ok, am_ok, mask_ok;

  assign eff_mask = adem_i & HI_MASK & width_mask_i;
  assign mask_ok  = |eff_mask;
  assign cmp_ok   = ((addr_t_i ^ ader_i) & eff_mask) == '0;
  assign cap_ok   = amcap_i[am_i];

  generate
    if (DECODE_AM) begin : g_am_field
      assign am_ok = (ader_i[AMF_LSB +: AM_W] == am_i);
    end else begin : g_am_free
      assign am_ok = 1'b1;
    end
  endgenerate

  assign match_o  = space_ok_i & mask_ok & cap_ok & am_ok & cmp_ok;
  assign offset_o = addr_t_i & ~eff_mask;
endmodule

// File: rtl/mfd_prio.sv
module mfd_prio #(
  parameter int unsigned N_FUNC = 8,
  localparam int unsigned FN_W  = (N_FUNC > 1) ? $clog2(N_FUNC) : 1
) (
  input  logic [N_FUNC-1:0] match_i,
  output logic              any_o,
  output logic [FN_W-1:0]   idx_o
);
  // lowest index wins: scan downward so the last write is the smallest
  always_comb begin
    any_o = |match_i;
    idx_o = '0;
    for (int i = N_FUNC - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = FN_W'(i);
    end
  end
endmodule

// File: rtl/multi_fn_decoder.sv
module multi_fn_decoder
  import mfd_pkg::*;
#(
  parameter int unsigned N_FUNC    = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MASK_LSB  = 8,
  parameter bit          DECODE_AM = 1'b1,
  localparam int unsigned FN_W     = (N_FUNC > 1) ? $clog2(N_FUNC) : 1,
  localparam int unsigned CAP_W    = 1 << AM_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [AM_W-1:0]                am_i,
  input  logic [N_FUNC-1:0][ADDR_W-1:0]  ader_i,
  input  logic [N_FUNC-1:0][ADDR_W-1:0]  adem_i,
  input  logic [N_FUNC-1:0][CAP_W-1:0]   amcap_i,
  output logic                           hit_o,
  output logic [FN_W-1:0]                fn_o,
  output logic [ADDR_W-1:0]              addr_o
);
  space_e                          space;
  logic [ADDR_W-1:0]               wmask, addr_t, sel_off;
  logic                            space_ok, any_hit;
  logic [N_FUNC-1:0]               match;
  logic [N_FUNC-1:0][ADDR_W-1:0]   offs;
  logic [FN_W-1:0]                 sel;

  mfd_space_class #(.ADDR_W(ADDR_W)) u_space (
    .am_i        (am_i),
    .space_o     (space),
    .width_mask_o(wmask)
  );

  assign space_ok = (space != SPACE_NONE);
  assign addr_t   = addr_i & wmask;

  generate
    for (genvar g = 0; g < N_FUNC; g++) begin : g_fn
      mfd_func #(
        .ADDR_W   (ADDR_W),
        .MASK_LSB (MASK_LSB),
        .DECODE_AM(DECODE_AM)
      ) u_fn (
        .addr_t_i    (addr_t),
        .width_mask_i(wmask),
        .space_ok_i  (space_ok),
        .am_i        (am_i),
        .ader_i      (ader_i[g]),
        .adem_i      (adem_i[g]),
        .amcap_i     (amcap_i[g]),
        .match_o     (match[g]),
        .offset_o    (offs[g])
      );
    end
  endgenerate

  mfd_prio #(.N_FUNC(N_FUNC)) u_prio (
    .match_i(match),
    .any_o  (any_hit),
    .idx_o  (sel)
  );

  assign sel_off = offs[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      fn_o   <= '0;
      addr_o <= '0;
    end else begin
      hit_o <= req_i & any_hit;
      if (req_i && any_hit) begin
        fn_o   <= sel;
        addr_o <= sel_off;
      end
    end
  end
endmodule

// File: rtl/mfd_chk.sv
module mfd_chk
  import mfd_pkg::*;
#(
  parameter int unsigned N_FUNC    = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MASK_LSB  = 8,
  parameter bit          DECODE_AM = 1'b1,
  localparam int unsigned FN_W     = (N_FUNC > 1) ? $clog2(N_FUNC) : 1,
  localparam int unsigned CAP_W    = 1 << AM_W
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [AM_W-1:0]               am_i,
  input logic [N_FUNC-1:0][ADDR_W-1:0] ader_i,
  input logic [N_FUNC-1:0][ADDR_W-1:0] adem_i,
  input logic [N_FUNC-1:0][CAP_W-1:0]  amcap_i,
  input logic                          hit_o,
  input logic [FN_W-1:0]               fn_o,
  input logic [ADDR_W-1:0]             addr_o
);
  localparam logic [ADDR_W-1:0] HI = {{(ADDR_W-MASK_LSB){1'b1}}, {MASK_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] LO = ~HI;

  logic [ADDR_W-1:0]              addr_q;
  logic [AM_W-1:0]                am_q;
  logic [N_FUNC-1:0][ADDR_W-1:0]  ader_q, adem_q;
  logic [N_FUNC-1:0][CAP_W-1:0]   cap_q;

  // inputs seen at the edge that produced the current outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0; am_q <= '0; ader_q <= '0; adem_q <= '0; cap_q <= '0;
    end else begin
      addr_q <= addr_i; am_q <= am_i; ader_q <= ader_i; adem_q <= adem_i; cap_q <= amcap_i;
    end
  end

  assert_idle_no_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !hit_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(fn_o) && $stable(addr_o)));

  assert_cap_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> cap_q[fn_o][am_q]);

  assert_mask_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((adem_q[fn_o] & HI) != '0));

  assert_low_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (((addr_o ^ addr_q) & LO) == '0));

  assert_masked_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((addr_o & adem_q[fn_o] & HI) == '0));

  generate
    if (DECODE_AM) begin : g_amf
      assert_am_field_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (((ader_q[fn_o] >> AMF_LSB) & ADDR_W'((1 << AM_W) - 1)) == ADDR_W'(am_q)));
    end
  endgenerate
endmodule

bind multi_fn_decoder mfd_chk #(
  .N_FUNC   (N_FUNC),
  .ADDR_W   (ADDR_W),
  .MASK_LSB (MASK_LSB),
  .DECODE_AM(DECODE_AM)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .addr_i (addr_i),
  .am_i   (am_i),
  .ader_i (ader_i),
  .adem_i (adem_i),
  .amcap_i(amcap_i),
  .hit_o  (hit_o),
  .fn_o   (fn_o),
  .addr_o (addr_o)
);

// File: tb/multi_fn_decoder_tb_top.sv
`timescale 1ns/1ps
module multi_fn_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [31:0] addr = '0;
  logic [5:0]  am = '0;
  logic [7:0][31:0] ader, adem;
  logic [7:0][63:0] amcap;

  logic        hit_a, hit_b;
  logic [2:0]  fn_a, fn_b;
  logic [31:0] off_a, off_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  multi_fn_decoder #(.DECODE_AM(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .am_i(am),
    .ader_i(ader), .adem_i(adem), .amcap_i(amcap),
    .hit_o(hit_a), .fn_o(fn_a), .addr_o(off_a));

  multi_fn_decoder #(.DECODE_AM(1'b0)) dut_noam_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .am_i(am),
    .ader_i(ader), .adem_i(adem), .amcap_i(amcap),
    .hit_o(hit_b), .fn_o(fn_b), .addr_o(off_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: width from code, first matching function
  function automatic void ref_decode(input logic [31:0] a, input logic [5:0] m, input bit use_am,
                                     output bit h, output int f, output logic [31:0] o);
    int bits;
    logic [31:0] wm, msk, at;
    h = 1'b0; f = 0; o = '0;
    if (m == 6'h29 || m == 6'h2D) bits = 16;
    else if (m >= 6'h38 || m == 6'h2F) bits = 24;
    else if (m >= 6'h08 && m <= 6'h0F) bits = 32;
    else bits = 0;
    if (bits == 0) return;
    wm = (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
    at = a & wm;
    for (int i = 7; i >= 0; i--) begin
      msk = adem[i] & 32'hFFFF_FF00 & wm;
      if (msk != 0 && amcap[i][m] && (!use_am || ader[i][7:2] == m) &&
          ((at & msk) == (ader[i] & msk))) begin
        h = 1'b1; f = i; o = at & ~msk;
      end
    end
  endfunction

  bit          mh [2];
  int          mf [2];
  logic [31:0] mo [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin mh[k] = 1'b0; mf[k] = 0; mo[k] = '0; end
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit h; int f; logic [31:0] o;
        ref_decode(addr, am, (k == 0), h, f, o);
        mh[k] = req && h;
        if (req && h) begin mf[k] = f; mo[k] = o; end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R9 model hit A", {31'd0, hit_a}, {31'd0, mh[0]});
      chk("R9 model fn A",  {29'd0, fn_a},  mf[0]);
      chk("R9 model addr A", off_a, mo[0]);
      chk("R9 model hit B", {31'd0, hit_b}, {31'd0, mh[1]});
      chk("R9 model fn B",  {29'd0, fn_b},  mf[1]);
      chk("R9 model addr B", off_b, mo[1]);
    end
  end

  task automatic drive(input bit r, input logic [31:0] a, input logic [5:0] m);
    req = r; addr = a; am = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input bit ha, input int fa, input logic [31:0] oa,
                            input bit hb, input int fb, input logic [31:0] ob);
    chk({tag, " hit A"}, {31'd0, hit_a}, {31'd0, ha});
    chk({tag, " fn A"}, {29'd0, fn_a}, fa);
    chk({tag, " addr A"}, off_a, oa);
    chk({tag, " hit B"}, {31'd0, hit_b}, {31'd0, hb});
    chk({tag, " fn B"}, {29'd0, fn_b}, fb);
    chk({tag, " addr B"}, off_b, ob);
  endtask

  initial begin
    ader = '0; adem = '0; amcap = '0;
    ader[0] = 32'h1234_0000 | (32'h09 << 2); adem[0] = 32'hFFFF_0000;
    amcap[0] = (64'd1 << 6'h09) | (64'd1 << 6'h0B);
    ader[1] = 32'h0050_0000 | (32'h39 << 2); adem[1] = 32'h00F0_0000;
    amcap[1] = (64'd1 << 6'h39) | (64'd1 << 6'h3B);
    ader[2] = 32'h0000_C000 | (32'h29 << 2); adem[2] = 32'h0000_F000;
    amcap[2] = (64'd1 << 6'h29);
    ader[3] = 32'h1234_0000 | (32'h09 << 2); adem[3] = 32'hFF00_0000;
    amcap[3] = (64'd1 << 6'h09);
    ader[4] = 32'h0000_0000;                 adem[4] = 32'h0000_0000;
    amcap[4] = 64'hFFFF_FFFF_FFFF_FFFF;
    ader[5] = 32'h0000_0000 | (32'h09 << 2); adem[5] = 32'h8000_0000;
    amcap[5] = 64'd0;
    ader[6] = 32'hA000_0000 | (32'h08 << 2); adem[6] = 32'hF000_0000;
    amcap[6] = (64'd1 << 6'h08) | (64'd1 << 6'h0B);
    ader[7] = 32'h0100_0000 | (32'h39 << 2); adem[7] = 32'hFF00_0000;
    amcap[7] = (64'd1 << 6'h39);

    repeat (3) @(negedge clk);
    req = 1'b1; addr = 32'h1234_5678; am = 6'h09;
    @(negedge clk);
    expect_out("R1 reset", 0, 0, 32'h0, 0, 0, 32'h0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    drive(1, 32'h1234_5678, 6'h09);  // fn0 and fn3 both match
    expect_out("R6 R3 R8 overlap", 1, 0, 32'h5678, 1, 0, 32'h5678);
    drive(0, 32'h1299_0000, 6'h09);
    expect_out("R9 idle hold", 0, 0, 32'h5678, 0, 0, 32'h5678);
    drive(1, 32'h1234_0000, 6'h0D);
    expect_out("R4 cap missing", 0, 0, 32'h5678, 0, 0, 32'h5678);
    drive(1, 32'h1299_0000, 6'h09);
    expect_out("R3 wide mask fn3", 1, 3, 32'h0099_0000, 1, 3, 32'h0099_0000);
    drive(1, 32'hAB50_1234, 6'h39);
    expect_out("R2 A24 truncate", 1, 1, 32'h0000_1234, 1, 1, 32'h0000_1234);
    drive(1, 32'hFFFF_C123, 6'h29);
    expect_out("R2 A16 truncate", 1, 2, 32'h0000_0123, 1, 2, 32'h0000_0123);
    drive(1, 32'hFFFF_C123, 6'h2D);
    expect_out("R4 A16 other code", 0, 2, 32'h0123, 0, 2, 32'h0123);
    drive(1, 32'h1234_0004, 6'h0B);
    expect_out("R5 am field fn0", 0, 2, 32'h0123, 1, 0, 32'h0004);
    drive(1, 32'hA000_0010, 6'h0B);
    expect_out("R5 am field fn6", 0, 2, 32'h0123, 1, 6, 32'h0010);
    drive(1, 32'hA000_0010, 6'h08);
    expect_out("R5 am field equal", 1, 6, 32'h0010, 1, 6, 32'h0010);
    drive(1, 32'h0100_0000, 6'h39);
    expect_out("R7 mask above width", 0, 6, 32'h0010, 0, 6, 32'h0010);
    drive(1, 32'h0000_0000, 6'h09);
    expect_out("R7 empty cap", 0, 6, 32'h0010, 0, 6, 32'h0010);
    drive(1, 32'h1234_5678, 6'h20);
    expect_out("R2 invalid code", 0, 6, 32'h0010, 0, 6, 32'h0010);
    drive(1, 32'h1234_5678, 6'h09);
    expect_out("R6 lowest wins", 1, 0, 32'h5678, 1, 0, 32'h5678);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] base;
      logic [5:0]  code;
      case ($urandom_range(0, 6))
        0: base = 32'h1234_0000; 1: base = 32'h1299_0000; 2: base = 32'h0050_0000;
        3: base = 32'h0000_C000; 4: base = 32'hA000_0000; 5: base = 32'h0100_0000;
        default: base = $urandom;
      endcase
      case ($urandom_range(0, 9))
        0: code = 6'h09; 1: code = 6'h0B; 2: code = 6'h0D; 3: code = 6'h39; 4: code = 6'h3B;
        5: code = 6'h29; 6: code = 6'h2D; 7: code = 6'h08; 8: code = 6'h2F;
        default: code = 6'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) base = base | ($urandom & 32'hFF00_0000);
      drive($urandom_range(0, 4) != 0, base | ($urandom & 32'h0000_0FFF), code);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule